// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps through a microprogram held in a built-in 64-word control memory. A control address register holds the address of the current microinstruction. A control buffer register holds the word read from that address. On every clock the sequencer works out the next control address and loads both registers together. The next address comes from one of three sources: the current address plus one, the address field of a branch word, or an opcode mapping that gives each machine instruction a four-word routine.

Each 16-bit microinstruction has one of two formats, chosen by its top bit. A control word drives its fifteen low bits out as control lines and then moves on to the next address. A branch word drives no control lines. It tests one of the datapath flags, or it dispatches on the machine opcode. The flags and the opcode are sampled in the same cycle that the branch word sits in the buffer register.

Top module: `useq_sequencer`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, `uaddr` is 0 and `ctl_lines` is 0. After the first clock edge with reset released, `uaddr` is still 0 and `ctl_lines` shows the word stored at address 0.
- R2: When the buffered word has bit 15 = 0 (control format), `ctl_lines` equals its bits 14:0, and after the next edge `uaddr` is the old `uaddr` plus one, modulo 64.
- R3: When the buffered word has bit 15 = 1 (branch format), `ctl_lines` is all zeros.
- R4: A branch word with condition code 0 in bits 14:12 always loads bits 5:0 of the word into `uaddr` at the next edge.
- R5: Condition codes 1 (zero set), 2 (negative set), 3 (carry set) and 4 (zero clear) test the flag inputs present in the cycle the branch word is buffered. When the test holds, the next `uaddr` is bits 5:0 of the word. When it fails, the next `uaddr` is the old `uaddr` plus one.
- R6: Condition code 5 loads `uaddr` with `opcode` shifted left by two, so opcode k enters its routine at address 4k.
- R7: Condition codes 6 and 7 are never taken: the next `uaddr` is the old `uaddr` plus one.
- R8: The control memory holds the following. Addresses 0, 1 and 2 are control words 0x0001, 0x0002 and 0x0004, and address 3 is a dispatch (0xD000). For k = 1..15, address 4k is a control word with k in bits 7:4 and bit 0 set. Address 4k+1 is a branch word with condition code k mod 8 and target 4k+3. Address 4k+2 is a control word with k in bits 7:4 and bit 1 set. Address 4k+3 is 0x8000, which branches back to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 4 | Machine opcode used for dispatch |
| flag_zero | input | 1 | Zero flag from the datapath |
| flag_neg | input | 1 | Negative flag from the datapath |
| flag_carry | input | 1 | Carry flag from the datapath |
| uaddr | output | 6 | Control address register (address of the buffered word) |
| ctl_lines | output | 15 | Control lines of the buffered control word; zero for branch words |

## Verification
The bound checker tests the cycle-to-cycle address rules on every cycle. It checks that control words step by one, that branch words keep the control lines quiet, and that an always-branch lands on its target. It also checks that dispatch lands on the opcode routine, that the never codes fall through, and that a zero-flag branch goes to its target when the flag is set. The contents of the control memory, the exact values on the control lines, and the full flag and opcode path through every routine can only be shown by the bench. Its random opcode and flag stream is replayed through its own model of the microprogram, and a reset taken in the middle of a run is checked the same way.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int UA_W     = 6;
  localparam int UW_W     = 16;
  localparam int OP_W     = 4;
  localparam int ROUT_SH  = 2;
  localparam int CTL_W    = UW_W - 1;
  localparam int FMT_BIT  = UW_W - 1;
  localparam int CS_HI    = 14;
  localparam int CS_LO    = 12;

  typedef enum logic [2:0] {
    CS_ALWAYS = 3'd0,
    CS_ZERO   = 3'd1,
    CS_NEG    = 3'd2,
    CS_CARRY  = 3'd3,
    CS_NZERO  = 3'd4,
    CS_DISP   = 3'd5,
    CS_NEVER6 = 3'd6,
    CS_NEVER7 = 3'd7
  } cond_sel_e;

  function automatic logic [UA_W-1:0] addr_step(input logic [UA_W-1:0] a);
    return a + UA_W'(1);
  endfunction

  function automatic logic [UA_W-1:0] op_map(input logic [OP_W-1:0] op);
    return UA_W'({op, {ROUT_SH{1'b0}}});
  endfunction

  // Microprogram: fetch at 0..3, four-word routine per opcode after it.
  function automatic logic [UW_W-1:0] rom_word(input int unsigned a);
    logic [UA_W-1:0] a6;
    logic [3:0]      k;
    logic [1:0]      slot;
    logic [UW_W-1:0] w;
    a6   = UA_W'(a);
    k    = a6[5:2];
    slot = a6[1:0];
    w    = '0;
    if (k == 4'd0) begin
      if (slot == 2'd3) begin
        w[FMT_BIT]     = 1'b1;
        w[CS_HI:CS_LO] = CS_DISP;
      end else begin
        w[slot] = 1'b1;
      end
    end else begin
      case (slot)
        2'd0: begin w[7:4] = k; w[0] = 1'b1; end
        2'd1: begin
          w[FMT_BIT]     = 1'b1;
          w[CS_HI:CS_LO] = k[2:0];
          w[UA_W-1:0]    = a6 + UA_W'(2);
        end
        2'd2: begin w[7:4] = k; w[1] = 1'b1; end
        default: w[FMT_BIT] = 1'b1;
      endcase
    end
    return w;
  endfunction
endpackage

// File: rtl/useq_cmem.sv
module useq_cmem #(
  parameter int AW = useq_pkg::UA_W,
  parameter int DW = useq_pkg::UW_W
) (
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] word
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = DW'(useq_pkg::rom_word(i));
  end

  assign word = mem[addr];
endmodule

// File: rtl/useq_cond.sv
module useq_cond (
  input  logic [2:0] sel,
  input  logic       f_zero,
  input  logic       f_neg,
  input  logic       f_carry,
  output logic       take,
  output logic       disp
);
  import useq_pkg::*;
  always_comb begin
    take = 1'b0;
    disp = 1'b0;
    case (cond_sel_e'(sel))
      CS_ALWAYS: take = 1'b1;
      CS_ZERO:   take = f_zero;
      CS_NEG:    take = f_neg;
      CS_CARRY:  take = f_carry;
      CS_NZERO:  take = ~f_zero;
      CS_DISP:   disp = 1'b1;
      default:   take = 1'b0;
    endcase
  end
endmodule

// File: rtl/useq_next.sv
module useq_next #(
  parameter int AW  = useq_pkg::UA_W,
  parameter int OPW = useq_pkg::OP_W
) (
  input  logic           valid,
  input  logic           is_branch,
  input  logic           take,
  input  logic           disp,
  input  logic [AW-1:0]  car,
  input  logic [AW-1:0]  target,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  nxt
);
  import useq_pkg::*;
  always_comb begin
    if (!valid)                 nxt = car;
    else if (!is_branch)        nxt = addr_step(car);
    else if (disp)              nxt = op_map(opcode);
    else if (take)              nxt = target;
    else                        nxt = addr_step(car);
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int AW  = useq_pkg::UA_W,
  parameter int DW  = useq_pkg::UW_W,
  parameter int OPW = useq_pkg::OP_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic           flag_zero,
  input  logic           flag_neg,
  input  logic           flag_carry,
  output logic [AW-1:0]  uaddr,
  output logic [DW-2:0]  ctl_lines
);
  localparam int FB = DW - 1;

  logic [AW-1:0] car_q;
  logic [AW-1:0] nxt_addr;
  logic [DW-1:0] cbr_q;
  logic [DW-1:0] fetched;
  logic          cbr_valid;

  // Named internal events for the checker.
  logic          cbr_is_branch;
  logic [2:0]    cbr_cond;
  logic [AW-1:0] cbr_target;
  logic          take_branch;
  logic          dispatch;

  assign cbr_is_branch = cbr_q[FB];
  assign cbr_cond      = cbr_q[useq_pkg::CS_HI:useq_pkg::CS_LO];
  assign cbr_target    = cbr_q[AW-1:0];

  useq_cond u_cond (
    .sel     (cbr_cond),
    .f_zero  (flag_zero),
    .f_neg   (flag_neg),
    .f_carry (flag_carry),
    .take    (take_branch),
    .disp    (dispatch)
  );

  useq_next #(.AW(AW), .OPW(OPW)) u_next (
    .valid     (cbr_valid),
    .is_branch (cbr_is_branch),
    .take      (take_branch),
    .disp      (dispatch),
    .car       (car_q),
    .target    (cbr_target),
    .opcode    (opcode),
    .nxt       (nxt_addr)
  );

  useq_cmem #(.AW(AW), .DW(DW)) u_cmem (
    .addr (nxt_addr),
    .word (fetched)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q     <= '0;
      cbr_q     <= '0;
      cbr_valid <= 1'b0;
    end else begin
      car_q     <= nxt_addr;
      cbr_q     <= fetched;
      cbr_valid <= 1'b1;
    end
  end

  assign uaddr     = car_q;
  assign ctl_lines = (cbr_valid && !cbr_is_branch) ? cbr_q[DW-2:0] : '0;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int AW  = useq_pkg::UA_W,
  parameter int CW  = useq_pkg::CTL_W,
  parameter int OPW = useq_pkg::OP_W
) (
  input logic           clk,
  input logic           rst_n,
  input logic [OPW-1:0] opcode,
  input logic           flag_zero,
  input logic [AW-1:0]  uaddr,
  input logic [CW-1:0]  ctl_lines,
  input logic           cbr_valid,
  input logic           cbr_is_branch,
  input logic [2:0]     cbr_cond,
  input logic [AW-1:0]  cbr_target
);
  logic br_v;
  assign br_v = cbr_valid && cbr_is_branch;

  p_first_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cbr_valid |=> uaddr == '0);

  p_ctl_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cbr_valid && !cbr_is_branch) |=> uaddr == AW'($past(uaddr) + AW'(1)));

  p_branch_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    br_v |-> ctl_lines == '0);

  p_always_jump_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_v && cbr_cond == 3'd0) |=> uaddr == $past(cbr_target));

  p_zero_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (br_v && cbr_cond == 3'd1 && flag_zero) |=> uaddr == $past(cbr_target));

  p_dispatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (br_v && cbr_cond == 3'd5) |=> uaddr == AW'({$past(opcode), 2'b00}));

  p_never_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (br_v && cbr_cond[2:1] == 2'b11) |=> uaddr == AW'($past(uaddr) + AW'(1)));
endmodule

bind useq_sequencer useq_sequencer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .opcode        (opcode),
  .flag_zero     (flag_zero),
  .uaddr         (uaddr),
  .ctl_lines     (ctl_lines),
  .cbr_valid     (cbr_valid),
  .cbr_is_branch (cbr_is_branch),
  .cbr_cond      (cbr_cond),
  .cbr_target    (cbr_target)
);

// File: tb/useq_sequencer_tb.sv
module useq_sequencer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode = '0;
  logic       flag_zero = 1'b0, flag_neg = 1'b0, flag_carry = 1'b0;
  logic [5:0] uaddr;
  logic [14:0] ctl_lines;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  useq_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .flag_zero(flag_zero), .flag_neg(flag_neg), .flag_carry(flag_carry),
    .uaddr(uaddr), .ctl_lines(ctl_lines)
  );

  // Independent restatement of the microprogram (R8).
  function automatic logic [15:0] exp_word(input int a);
    int k = a / 4;
    int s = a % 4;
    if (a < 3) return 16'(1 << a);
    if (a == 3) return 16'hD000;
    if (s == 0) return 16'(k * 16 + 1);
    if (s == 2) return 16'(k * 16 + 2);
    if (s == 3) return 16'h8000;
    return 16'(32768 + (k % 8) * 4096 + a + 2);
  endfunction

  function automatic logic [14:0] exp_ctl(input bit v, input int a);
    logic [15:0] w = exp_word(a);
    if (!v || w[15]) return '0;
    return w[14:0];
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  int    m_car   = 0;
  bit    m_valid = 1'b0;
  string m_tag   = "R1";

  task automatic step_model();
    logic [15:0] w;
    int c, nxt;
    bit tk;
    w = exp_word(m_car);
    if (!m_valid) begin nxt = 0; m_tag = "R1"; end
    else if (!w[15]) begin nxt = (m_car + 1) % 64; m_tag = "R2"; end
    else begin
      c = int'(w[14:12]);
      case (c)
        0: begin tk = 1; m_tag = "R4"; end
        1: begin tk = flag_zero;  m_tag = "R5"; end
        2: begin tk = flag_neg;   m_tag = "R5"; end
        3: begin tk = flag_carry; m_tag = "R5"; end
        4: begin tk = !flag_zero; m_tag = "R5"; end
        default: begin tk = 0; m_tag = "R7"; end
      endcase
      if (c == 5) begin nxt = int'(opcode) * 4; m_tag = "R6"; end
      else nxt = tk ? int'(w[5:0]) : (m_car + 1) % 64;
    end
    @(posedge clk);
    m_car = nxt;
    m_valid = 1'b1;
  endtask

  task automatic check_outputs();
    string ctag;
    ctag = (m_valid && exp_word(m_car)[15]) ? "R3" : "R8";
    if (!m_valid) ctag = "R1";
    check(m_tag, int'(uaddr), m_car);
    check(ctag, int'(ctl_lines), int'(exp_ctl(m_valid, m_car)));
  endtask

  task automatic run(input int cycles, input bit directed);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_outputs();
      if (directed) begin
        opcode = 4'd0; flag_zero = 1'b0; flag_neg = 1'b0; flag_carry = 1'b0;
      end else begin
        opcode     = 4'($urandom_range(0, 15));
        flag_zero  = 1'($urandom_range(0, 1));
        flag_neg   = 1'($urandom_range(0, 1));
        flag_carry = 1'($urandom_range(0, 1));
      end
      step_model();
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", int'(uaddr), 0);
    check("R1", int'(ctl_lines), 0);
    rst_n = 1'b1;
    m_car = 0; m_valid = 1'b0; m_tag = "R1";
    step_model();
    run(40, 1'b1);
    run(1500, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", int'(uaddr), 0);
    check("R1", int'(ctl_lines), 0);
    rst_n = 1'b1;
    m_car = 0; m_valid = 1'b0; m_tag = "R1";
    step_model();
    run(1500, 1'b0);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 100000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule